// File: doc/BRIEF.md
# Ethernet MAC Control and Abort Sequencer

This block holds the three control bits of a small Ethernet MAC and turns writes to them into timed actions on the MAC datapath. These are a self-clearing local reset, a MAC enable and a transmit retime selector. It gives the receive engine its run permission and the transmit engine its start permission. It tells the transmit engine when to finish an in-flight frame with a corrupted CRC, and it pulses a flush to the DMA, descriptor and FIFO control logic whenever the MAC is turned off.

Clearing the enable bit stops reception at once. A transmit frame that is in progress is still allowed to close, and the transmit engine inverts its final CRC for that frame. The block keeps the descriptor write-back inhibited until the engine reports the frame as done, and only then does it raise transmit stop. A local reset ends everything abruptly instead. The MII transmit nibble, enable and error can be launched on the rising edge of the transmit clock or, with retime set, half a period later on its falling edge.

Top module: `mac_ctrl_seq`

## Requirements
- R1: The control word reads as bit 2 = retime, bit 1 = enable, bit 0 = local reset busy, with bits 31 to 3 always reading 0. After rst the whole word reads 0.
- R2: A write with bit 0 set starts a local reset. local_rst goes high, enable goes to 0, retime takes bit 2 of the written word, and no corrupt_crc is raised.
- R3: After such a write, bit 0 and local_rst read 1 for exactly 16 clock cycles and then return to 0 by themselves.
- R4: rx_enable equals the enable bit. It falls in the first cycle in which the enable bit reads 0.
- R5: If enable goes from 1 to 0 by a write while tx_active is high, corrupt_crc is high for exactly that first disabled cycle. tx_stop stays 0 until the cycle in which tx_frame_done is high, and reads 1 from the next cycle on (enable still 0).
- R6: bd_wb_inhibit is high from the first disabled cycle of such an abort through the cycle in which tx_frame_done is high, and low otherwise.
- R7: dma_flush is a one-cycle pulse in the first cycle in which the enable bit reads 0 after reading 1, whether the cause was a write or a local reset.
- R8: While a local reset is in progress, every write is ignored. A single write with bits 0 and 1 both set leaves enable at 0 and starts the reset.
- R9: With no abort draining, tx_stop is 1 whenever enable reads 0 and clears in the same cycle enable reads 1. tx_start_ok is high only when enable reads 1, no abort is draining and no local reset is running.
- R10: With retime 0, mii_txd, mii_tx_en and mii_tx_er take the engine values at the next rising tx_clk edge. With retime 1, they change only at the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| tx_active | input | 1 | Transmit engine has a frame in flight |
| tx_frame_done | input | 1 | Transmit engine finished the current frame |
| rx_enable | output | 1 | Receive engine may run |
| local_rst | output | 1 | Local MAC reset, aborts all traffic |
| dma_flush | output | 1 | Reset pulse for DMA, descriptor and FIFO pointers |
| corrupt_crc | output | 1 | Request to invert the final CRC of the current frame |
| tx_stop | output | 1 | Transmit is stopped |
| tx_start_ok | output | 1 | A new transmit frame may start |
| bd_wb_inhibit | output | 1 | Suppress descriptor status write-back |
| tx_clk | input | 1 | MII transmit clock |
| eng_txd | input | 4 | Transmit nibble from the engine |
| eng_tx_en | input | 1 | Transmit enable from the engine |
| eng_tx_er | input | 1 | Transmit error from the engine |
| mii_txd | output | 4 | Transmit nibble to the PHY |
| mii_tx_en | output | 1 | Transmit enable to the PHY |
| mii_tx_er | output | 1 | Transmit error to the PHY |

## Verification
On every cycle, the embedded properties check several rules. The local reset ends after its last count and keeps enable cleared. Writes during a reset cannot raise enable. corrupt_crc and dma_flush never last two cycles. tx_stop stays low while an abort drains. Start permission implies enable. A disabling write drops rx_enable. Other points can only be shown by the bench scenarios, where a cycle-level reference model is compared each clock: the exact 16-cycle reset length, abrupt reset during a frame, frame_done landing in the disable cycle, re-enabling during a drain, and the half-period shift of the MII outputs.

// File: rtl/mac_ctrl_pkg.sv
package mac_ctrl_pkg;

    localparam int CTRL_W     = 32;
    localparam int BIT_RST    = 0;
    localparam int BIT_EN     = 1;
    localparam int BIT_RETIME = 2;

    typedef struct packed {
        logic retime;
        logic enable;
        logic busy;
    } ctrl_state_t;

    typedef struct packed {
        logic [3:0] txd;
        logic       tx_en;
        logic       tx_er;
    } mii_tx_t;

    function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_state_t s);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[BIT_RETIME] = s.retime;
        w[BIT_EN]     = s.enable;
        w[BIT_RST]    = s.busy;
        return w;
    endfunction

endpackage

// File: rtl/mac_ctrl_regs.sv
module mac_ctrl_regs
    import mac_ctrl_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_state_t       st,
    output logic              flush,
    output logic              dis_pulse
);
    localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    ctrl_state_t   nxt;
    logic [CW-1:0] cnt, nxt_cnt;
    logic          start_rst;

    always_comb begin
        nxt       = st;
        nxt_cnt   = cnt;
        start_rst = 1'b0;
        if (st.busy) begin
            if (cnt == LAST) begin
                nxt.busy = 1'b0;
                nxt_cnt  = '0;
            end else begin
                nxt_cnt = cnt + 1'b1;
            end
        end else if (wr) begin
            nxt.retime = wdata[BIT_RETIME];
            if (wdata[BIT_RST]) begin
                start_rst  = 1'b1;
                nxt.busy   = 1'b1;
                nxt.enable = 1'b0;
                nxt_cnt    = '0;
            end else begin
                nxt.enable = wdata[BIT_EN];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            cnt       <= '0;
            flush     <= 1'b0;
            dis_pulse <= 1'b0;
        end else begin
            st        <= nxt;
            cnt       <= nxt_cnt;
            flush     <= st.enable & ~nxt.enable;
            dis_pulse <= st.enable & ~nxt.enable & ~start_rst;
        end
    end

    AST_RST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st.busy && cnt == LAST) |=> !st.busy);                       // R3
    AST_RST_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(st.busy) |-> !st.enable);                               // R2
    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st.busy && wr) |=> !st.enable);                              // R8
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);                                            // R7

endmodule

// File: rtl/mac_tx_abort.sv
module mac_tx_abort (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic en,
    input  logic dis_pulse,
    input  logic tx_active,
    input  logic tx_frame_done,
    output logic corrupt_crc,
    output logic tx_stop,
    output logic tx_start_ok,
    output logic bd_wb_inhibit
);
    logic draining_q;
    logic drain_now;

    assign corrupt_crc   = dis_pulse & tx_active;
    assign drain_now     = draining_q | corrupt_crc;
    assign bd_wb_inhibit = drain_now;
    assign tx_stop       = ~en & ~drain_now;
    assign tx_start_ok   = en & ~draining_q & ~busy;

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            draining_q <= 1'b0;
        end else begin
            draining_q <= drain_now & ~tx_frame_done;
        end
    end

    AST_CRC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        corrupt_crc |=> !corrupt_crc);                                // R5
    AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
        (drain_now && !tx_frame_done && !busy) |=> !tx_stop);         // R5
    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        tx_start_ok |-> (en && !busy));                               // R9

endmodule

// File: rtl/mac_mii_retime.sv
module mac_mii_retime
    import mac_ctrl_pkg::*;
(
    input  logic    tx_clk,
    input  logic    rst,
    input  logic    retime,
    input  mii_tx_t d,
    output mii_tx_t q
);
    mii_tx_t rise_q, fall_q;

    always_ff @(posedge tx_clk) begin
        if (rst) rise_q <= '0;
        else     rise_q <= d;
    end

    always_ff @(negedge tx_clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= rise_q;
    end

    assign q = retime ? fall_q : rise_q;

endmodule

// File: rtl/mac_ctrl_seq.sv
module mac_ctrl_seq
    import mac_ctrl_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_active,
    input  logic        tx_frame_done,
    output logic        rx_enable,
    output logic        local_rst,
    output logic        dma_flush,
    output logic        corrupt_crc,
    output logic        tx_stop,
    output logic        tx_start_ok,
    output logic        bd_wb_inhibit,
    input  logic        tx_clk,
    input  logic [3:0]  eng_txd,
    input  logic        eng_tx_en,
    input  logic        eng_tx_er,
    output logic [3:0]  mii_txd,
    output logic        mii_tx_en,
    output logic        mii_tx_er
);
    ctrl_state_t st;
    logic        dis_pulse;
    mii_tx_t     eng_bus, phy_bus;

    mac_ctrl_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .st        (st),
        .flush     (dma_flush),
        .dis_pulse (dis_pulse)
    );

    mac_tx_abort u_abort (
        .clk           (clk),
        .rst           (rst),
        .busy          (st.busy),
        .en            (st.enable),
        .dis_pulse     (dis_pulse),
        .tx_active     (tx_active),
        .tx_frame_done (tx_frame_done),
        .corrupt_crc   (corrupt_crc),
        .tx_stop       (tx_stop),
        .tx_start_ok   (tx_start_ok),
        .bd_wb_inhibit (bd_wb_inhibit)
    );

    assign eng_bus = '{txd: eng_txd, tx_en: eng_tx_en, tx_er: eng_tx_er};

    mac_mii_retime u_mii (
        .tx_clk (tx_clk),
        .rst    (rst),
        .retime (st.retime),
        .d      (eng_bus),
        .q      (phy_bus)
    );

    assign mii_txd   = phy_bus.txd;
    assign mii_tx_en = phy_bus.tx_en;
    assign mii_tx_er = phy_bus.tx_er;

    assign reg_rdata = pack_ctrl(st);
    assign rx_enable = st.enable;
    assign local_rst = st.busy;

    AST_RX_STOPS: assert property (@(posedge clk) disable iff (rst)
        (rx_enable && reg_wr && !reg_wdata[BIT_EN]) |=> !rx_enable);  // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[31:3] == '0));                          // R1

endmodule

// File: tb/mac_ctrl_seq_test.sv
module mac_ctrl_seq_test;
    logic        clk = 1'b0, tx_clk = 1'b0, rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_active = 1'b0, tx_frame_done = 1'b0;
    logic        rx_enable, local_rst, dma_flush, corrupt_crc;
    logic        tx_stop, tx_start_ok, bd_wb_inhibit;
    logic [3:0]  eng_txd = '0, mii_txd;
    logic        eng_tx_en = 1'b0, eng_tx_er = 1'b0, mii_tx_en, mii_tx_er;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_on = 0, done = 0;
    int m_en = 0, m_ret = 0, m_busy = 0, m_cnt = 0, m_flush = 0, m_dis = 0, m_drain = 0;

    always #4  clk = ~clk;
    always #20 tx_clk = ~tx_clk;

    mac_ctrl_seq uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // reference model, updated at each rising edge
    always @(posedge clk) begin
        int prev_en, crc, dnow, started;
        if (rst) begin
            m_en = 0; m_ret = 0; m_busy = 0; m_cnt = 0; m_flush = 0; m_dis = 0; m_drain = 0;
        end else begin
            prev_en = m_en; started = 0;
            crc  = (m_dis != 0 && tx_active) ? 1 : 0;
            dnow = (m_drain != 0 || crc != 0) ? 1 : 0;
            if (m_busy != 0) m_drain = 0;
            else m_drain = (dnow != 0 && !tx_frame_done) ? 1 : 0;
            if (m_busy != 0) begin
                m_cnt++;
                if (m_cnt == 16) begin m_busy = 0; m_cnt = 0; end
            end else if (reg_wr) begin
                m_ret = reg_wdata[2];
                if (reg_wdata[0]) begin m_busy = 1; m_cnt = 0; m_en = 0; started = 1; end
                else m_en = reg_wdata[1];
            end
            m_flush = (prev_en != 0 && m_en == 0) ? 1 : 0;
            m_dis   = (m_flush != 0 && started == 0) ? 1 : 0;
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        int crc, dnow;
        #3;
        if (cmp_on && !done) begin
            crc  = (m_dis != 0 && tx_active) ? 1 : 0;
            dnow = (m_drain != 0 || crc != 0) ? 1 : 0;
            chk("R1 reg_rdata", reg_rdata, {29'd0, m_ret[0], m_en[0], m_busy[0]});
            chk("R4 rx_enable", 32'(rx_enable), 32'(m_en));
            chk("R3 local_rst", 32'(local_rst), 32'(m_busy));
            chk("R7 dma_flush", 32'(dma_flush), 32'(m_flush));
            chk("R5 corrupt_crc", 32'(corrupt_crc), 32'(crc));
            chk("R6 bd_wb_inhibit", 32'(bd_wb_inhibit), 32'(dnow));
            chk("R9 tx_stop", 32'(tx_stop), 32'((m_en == 0 && dnow == 0) ? 1 : 0));
            chk("R9 tx_start_ok", 32'(tx_start_ok),
                32'((m_en != 0 && m_drain == 0 && m_busy == 0) ? 1 : 0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic mii_send(input logic [5:0] v);
        @(posedge tx_clk); #1 {eng_txd, eng_tx_en, eng_tx_er} = v;
    endtask

    initial begin
        int n;
        repeat (12) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset word", reg_rdata, 32'h0);
        chk("R9 reset tx_stop", 32'(tx_stop), 32'd1);
        cmp_on = 1;

        // enable while idle
        wr(32'h2);
        chk("R9 tx_stop clears with enable", 32'(tx_stop), 32'd0);
        chk("R4 rx_enable up", 32'(rx_enable), 32'd1);
        wr(32'hFFFF_FFFA);
        chk("R1 reserved bits read 0", reg_rdata, 32'h2);
        idle(2);

        // idle disable: flush, no corrupt
        wr(32'h0);
        chk("R7 flush on idle disable", 32'(dma_flush), 32'd1);
        chk("R5 no corrupt when idle", 32'(corrupt_crc), 32'd0);
        idle(1);

        // disable during a frame
        wr(32'h2);
        tx_active = 1'b1;
        wr(32'h0);
        chk("R5 corrupt on disable", 32'(corrupt_crc), 32'd1);
        chk("R4 rx stops at once", 32'(rx_enable), 32'd0);
        chk("R5 tx_stop held", 32'(tx_stop), 32'd0);
        idle(4);
        chk("R6 inhibit while draining", 32'(bd_wb_inhibit), 32'd1);
        tx_frame_done = 1'b1;
        @(negedge clk); tx_frame_done = 1'b0; tx_active = 1'b0; #1;
        chk("R5 tx_stop after done", 32'(tx_stop), 32'd1);
        chk("R6 inhibit released", 32'(bd_wb_inhibit), 32'd0);

        // frame_done in the disable cycle
        wr(32'h2);
        tx_active = 1'b1;
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h0;
        @(negedge clk); reg_wr = 1'b0; tx_frame_done = 1'b1;
        @(negedge clk); tx_frame_done = 1'b0; tx_active = 1'b0; #1;
        chk("R5 stop after same-cycle done", 32'(tx_stop), 32'd1);

        // re-enable during drain
        wr(32'h2);
        tx_active = 1'b1;
        wr(32'h0);
        wr(32'h2);
        chk("R9 no start while draining", 32'(tx_start_ok), 32'd0);
        tx_frame_done = 1'b1;
        @(negedge clk); tx_frame_done = 1'b0; #1;
        chk("R9 start after drain", 32'(tx_start_ok), 32'd1);

        // local reset with enable set, frame active; write during reset ignored
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h3;
        @(negedge clk); reg_wr = 1'b0; #1;
        chk("R8 reset wins over enable", 32'(rx_enable), 32'd0);
        chk("R2 no corrupt on local reset", 32'(corrupt_crc), 32'd0);
        chk("R7 flush on local reset", 32'(dma_flush), 32'd1);
        n = 0;
        while (local_rst && n < 40) begin
            n++;
            if (n == 3) begin reg_wr = 1'b1; reg_wdata = 32'h6; end
            else reg_wr = 1'b0;
            @(negedge clk); #1;
        end
        reg_wr = 1'b0;
        tx_active = 1'b0;
        chk("R3 reset length", 32'(n), 32'd16);
        chk("R8 write during reset ignored", reg_rdata, 32'h0);

        // reset with retime bit
        wr(32'h5);
        chk("R2 retime taken on reset", reg_rdata, 32'h5);
        idle(18);

        // MII retime 0
        wr(32'h2);
        mii_send(6'h2A); mii_send(6'h2A);
        @(posedge tx_clk); #10;
        chk("R10 rise launch", {26'd0, mii_txd, mii_tx_en, mii_tx_er}, 32'h2A);
        mii_send(6'h15);
        @(posedge tx_clk); #10;
        chk("R10 rise launch next", {26'd0, mii_txd, mii_tx_en, mii_tx_er}, 32'h15);

        // MII retime 1
        wr(32'h6);
        mii_send(6'h15);
        mii_send(6'h33);
        @(posedge tx_clk); #10;
        chk("R10 held until falling edge", {26'd0, mii_txd, mii_tx_en, mii_tx_er}, 32'h15);
        #20;
        chk("R10 fall launch", {26'd0, mii_txd, mii_tx_en, mii_tx_er}, 32'h33);

        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule